// File: doc/BRIEF.md
# LIN Responder Sleep and Wakeup Timer

This block handles the low-power timing of a LIN responder node. It counts a millisecond tick while the node is awake. When the bus has been quiet for a selectable time, it puts the node to sleep and raises an idle-timeout flag. A sleep command takes the node to sleep at once. Any bus activity seen while asleep wakes the node, and that wakeup counts as received.

While the node sleeps, a wakeup request from the host starts a sequence. The block drives a wakeup pulse whose length is counted in bit-time ticks. It then leaves sleep and waits for a sync field. If none arrives within 150 ms, it flags a timeout and returns to sleep. Measured from the end of the previous pulse, it sends another pulse after a selectable repeat interval. After three unanswered pulses it stops and stays asleep until a new request arrives.

Top module: `lin_sleep_wake_ctl`

## Requirements
- R1: After reset the node is awake (sleep_o=0), wake_drive_o=0, and wake_stat_o, idle_to_o and sync_to_o are all 0.
- R2: While awake, the node sleeps when the number of ms_tick pulses since the last bus_act pulse reaches the idle limit. The limit is 4000, 6000, 8000 or 10000 for idle_sel 00, 01, 10 or 11. Expiry sets sleep_o=1 and idle_to_o=1 and clears wake_stat_o. One tick fewer leaves the node awake.
- R3: A bus_act pulse while awake restarts the idle count from zero.
- R4: A sleep_cmd pulse while awake puts the node to sleep on the next clock edge and clears wake_stat_o. idle_to_o stays 0.
- R5: A bus_act pulse while asleep wakes the node on the next edge: sleep_o=0, wake_stat_o=1, idle_to_o=0.
- R6: A wake_req pulse while asleep raises wake_drive_o on the next edge and sets wake_stat_o. The drive lasts wake_len+1 bit_tick pulses. sleep_o stays 1 while the pulse is driven and drops to 0 when it ends.
- R7: A sync_det pulse within 150 ms_tick pulses after a wakeup pulse keeps the node awake, and sync_to_o stays 0.
- R8: If 150 ms_tick pulses pass after a wakeup pulse with no sync_det, the block sets sync_to_o=1 and sleep_o=1.
- R9: The next wakeup pulse starts after 180, 200, 220 or 240 ms_tick pulses, counted from the end of the previous pulse, for rep_sel 00, 01, 10 or 11.
- R10: After the third unanswered pulse the block sends no further pulse and stays asleep. A new wake_req starts a fresh sequence and clears sync_to_o. Reaching the awake state also clears sync_to_o.
- R11: A wake_req pulse while awake has no effect: wake_drive_o stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle strobe per millisecond |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| bus_act | input | 1 | Strobe for activity seen on the bus |
| sync_det | input | 1 | Strobe for a detected sync field |
| sleep_cmd | input | 1 | Strobe for a received sleep command frame |
| wake_req | input | 1 | Host request to wake the bus |
| idle_sel | input | 2 | Idle time code (00 4 s, 01 6 s, 10 8 s, 11 10 s) |
| rep_sel | input | 2 | Repeat interval code (00 180 ms to 11 240 ms, 20 ms steps) |
| wake_len | input | WLEN_W | Wakeup pulse length minus one, in bit times |
| sleep_o | output | 1 | Node is in sleep |
| wake_drive_o | output | 1 | Drive the dominant wakeup level on the bus |
| wake_stat_o | output | 1 | A wakeup was sent or received |
| idle_to_o | output | 1 | Sleep was entered through the idle timeout |
| sync_to_o | output | 1 | A wakeup pulse got no sync field in time |

## Verification
A wrong count in the idle or window counters moves the edge of sleep_o or wake_drive_o by whole milliseconds. The bench therefore samples one tick before and at each limit, so an off-by-one shows on the first frame. A wrong state transition shows within a cycle as a wrong combination of the five outputs. One example is sleep_o staying high after a pulse, or a drive starting while the node is awake. A wrong retry count shows as a fourth pulse, which holds wake_drive_o high because no bit tick ends it.

// File: rtl/lin_sw_pkg.sv
package lin_sw_pkg;

   typedef enum logic [2:0] {
      ST_AWAKE  = 3'd0,
      ST_ASLEEP = 3'd1,
      ST_PULSE  = 3'd2,
      ST_WAIT   = 3'd3,
      ST_GAP    = 3'd4
   } pwr_st_e;

   // idle limit in ms ticks: (base + step*code) seconds
   function automatic int idle_limit(input logic [1:0] sel, input int base_s,
                                     input int step_s, input int unit_ms);
      return (base_s + step_s * int'(sel)) * unit_ms;
   endfunction

   // repeat interval in ms ticks: base + step*code
   function automatic int rep_limit(input logic [1:0] sel, input int base_ms,
                                    input int step_ms);
      return base_ms + step_ms * int'(sel);
   endfunction

endpackage

// File: rtl/lin_sw_idle_timer.sv
module lin_sw_idle_timer #(
   parameter int UNIT_MS = 1000,
   parameter int BASE_S  = 4,
   parameter int STEP_S  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       restart,
   input  logic       tick,
   input  logic [1:0] sel,
   output logic       expire
);
   localparam int MAXL = (BASE_S + 3 * STEP_S) * UNIT_MS;
   localparam int CW   = $clog2(MAXL + 1);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] lim;
   logic          hit;

   assign lim    = CW'(lin_sw_pkg::idle_limit(sel, BASE_S, STEP_S, UNIT_MS));
   assign hit    = (cnt_q >= (lim - 1'b1));
   assign expire = en & ~restart & tick & hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (!en || restart)  cnt_q <= '0;
      else if (tick)            cnt_q <= hit ? '0 : cnt_q + 1'b1;
   end

   p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < CW'(MAXL));

   p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
      restart |-> !expire);

endmodule

// File: rtl/lin_sw_pulse_gen.sv
module lin_sw_pulse_gen #(
   parameter int WLEN_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              bit_tick,
   input  logic [WLEN_W-1:0] wlen,
   output logic              done
);
   logic [WLEN_W-1:0] cnt_q;

   assign done = en & bit_tick & (cnt_q >= wlen);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (!en)            cnt_q <= '0;
      else if (bit_tick && !done) cnt_q <= cnt_q + 1'b1;
   end

   p_start_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !$past(en)) |-> cnt_q == '0);

endmodule

// File: rtl/lin_sw_window.sv
module lin_sw_window #(
   parameter int SYNC_MS     = 150,
   parameter int REP_BASE_MS = 180,
   parameter int REP_STEP_MS = 20
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       tick,
   input  logic [1:0] rep_sel,
   output logic       sync_exp,
   output logic       rep_exp
);
   localparam int MAXR = REP_BASE_MS + 3 * REP_STEP_MS;
   localparam int WW   = $clog2(MAXR + 1);

   logic [WW-1:0] cnt_q;
   logic [WW-1:0] rlim;

   assign rlim     = WW'(lin_sw_pkg::rep_limit(rep_sel, REP_BASE_MS, REP_STEP_MS));
   assign sync_exp = en & tick & (cnt_q == WW'(SYNC_MS - 1));
   assign rep_exp  = en & tick & (cnt_q >= (rlim - 1'b1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (!en)    cnt_q <= '0;
      else if (tick)   cnt_q <= rep_exp ? '0 : cnt_q + 1'b1;
   end

   p_win_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < WW'(MAXR));

endmodule

// File: rtl/lin_sleep_wake_ctl.sv
module lin_sleep_wake_ctl #(
   parameter int IDLE_UNIT_MS = 1000,
   parameter int IDLE_BASE_S  = 4,
   parameter int IDLE_STEP_S  = 2,
   parameter int SYNC_WAIT_MS = 150,
   parameter int REP_BASE_MS  = 180,
   parameter int REP_STEP_MS  = 20,
   parameter int MAX_TRIES    = 3,
   parameter int WLEN_W       = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ms_tick,
   input  logic              bit_tick,
   input  logic              bus_act,
   input  logic              sync_det,
   input  logic              sleep_cmd,
   input  logic              wake_req,
   input  logic [1:0]        idle_sel,
   input  logic [1:0]        rep_sel,
   input  logic [WLEN_W-1:0] wake_len,
   output logic              sleep_o,
   output logic              wake_drive_o,
   output logic              wake_stat_o,
   output logic              idle_to_o,
   output logic              sync_to_o
);
   import lin_sw_pkg::*;

   localparam int TW = $clog2(MAX_TRIES + 1);

   if (SYNC_WAIT_MS < 1 || SYNC_WAIT_MS >= REP_BASE_MS) begin : g_bad_window
      $error("sync wait must be at least 1 and shorter than the repeat base");
   end
   if (MAX_TRIES < 1) begin : g_bad_tries
      $error("at least one wakeup attempt is required");
   end
   if (WLEN_W < 1) begin : g_bad_wlen
      $error("wake length field needs at least one bit");
   end

   pwr_st_e        st_q, st_d;
   logic [TW-1:0]  tries_q;
   logic           idle_exp, pulse_done, sync_exp, rep_exp;
   logic           last_try, req_take, timeout, enter_awake;

   lin_sw_idle_timer #(
      .UNIT_MS (IDLE_UNIT_MS),
      .BASE_S  (IDLE_BASE_S),
      .STEP_S  (IDLE_STEP_S)
   ) u_idle (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (st_q == ST_AWAKE),
      .restart (bus_act),
      .tick    (ms_tick),
      .sel     (idle_sel),
      .expire  (idle_exp)
   );

   lin_sw_pulse_gen #(
      .WLEN_W (WLEN_W)
   ) u_pulse (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (st_q == ST_PULSE),
      .bit_tick (bit_tick),
      .wlen     (wake_len),
      .done     (pulse_done)
   );

   lin_sw_window #(
      .SYNC_MS     (SYNC_WAIT_MS),
      .REP_BASE_MS (REP_BASE_MS),
      .REP_STEP_MS (REP_STEP_MS)
   ) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       ((st_q == ST_WAIT) || (st_q == ST_GAP)),
      .tick     (ms_tick),
      .rep_sel  (rep_sel),
      .sync_exp (sync_exp),
      .rep_exp  (rep_exp)
   );

   assign last_try = (tries_q == TW'(MAX_TRIES - 1));
   assign req_take = (st_q == ST_ASLEEP) && !bus_act && wake_req;
   assign timeout  = (st_q == ST_WAIT) && !sync_det && sync_exp;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_AWAKE:  if (sleep_cmd || idle_exp) st_d = ST_ASLEEP;
         ST_ASLEEP: if (bus_act)               st_d = ST_AWAKE;
                    else if (wake_req)         st_d = ST_PULSE;
         ST_PULSE:  if (pulse_done)            st_d = ST_WAIT;
         ST_WAIT:   if (sync_det)              st_d = ST_AWAKE;
                    else if (sync_exp)         st_d = last_try ? ST_ASLEEP : ST_GAP;
         ST_GAP:    if (bus_act)               st_d = ST_AWAKE;
                    else if (rep_exp)          st_d = ST_PULSE;
         default:                              st_d = ST_AWAKE;
      endcase
   end

   assign enter_awake = (st_d == ST_AWAKE) && (st_q != ST_AWAKE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_AWAKE;
         tries_q     <= '0;
         wake_stat_o <= 1'b0;
         idle_to_o   <= 1'b0;
         sync_to_o   <= 1'b0;
      end else begin
         st_q <= st_d;

         if (req_take)     tries_q <= '0;
         else if (timeout) tries_q <= last_try ? '0 : tries_q + 1'b1;

         if ((st_q == ST_AWAKE) && (st_d == ST_ASLEEP))              wake_stat_o <= 1'b0;
         else if ((st_d == ST_PULSE) || ((st_q == ST_ASLEEP) && bus_act)) wake_stat_o <= 1'b1;

         if (enter_awake)                                           idle_to_o <= 1'b0;
         else if ((st_q == ST_AWAKE) && !sleep_cmd && idle_exp)     idle_to_o <= 1'b1;

         if (enter_awake || req_take) sync_to_o <= 1'b0;
         else if (timeout)            sync_to_o <= 1'b1;
      end
   end

   assign sleep_o      = (st_q == ST_ASLEEP) || (st_q == ST_PULSE) || (st_q == ST_GAP);
   assign wake_drive_o = (st_q == ST_PULSE);

   p_idle_sleep_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_exp && !sleep_cmd) |=> (sleep_o && idle_to_o));

   p_drive_not_awake_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wake_drive_o |-> ($past(st_q) != ST_AWAKE));

   p_sync_to_sleep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sync_to_o) |-> sleep_o);

   p_tries_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      tries_q < TW'(MAX_TRIES));

   p_pulse_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_done |=> (!wake_drive_o && !sleep_o));

endmodule

// File: tb/lin_sleep_wake_ctl_tb.sv
`timescale 1ns/1ps
module lin_sleep_wake_ctl_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ms_tick = 1'b0, bit_tick = 1'b0, bus_act = 1'b0, sync_det = 1'b0;
   logic       sleep_cmd = 1'b0, wake_req = 1'b0;
   logic [1:0] idle_sel = 2'b00, rep_sel = 2'b00;
   logic [2:0] wake_len = 3'd0;
   logic       sleep_o, wake_drive_o, wake_stat_o, idle_to_o, sync_to_o;

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   typedef struct {
      string      req;
      logic [4:0] v;
   } exp_t;

   exp_t sb_q[$];
   exp_t it;

   always #10 clk = ~clk;

   lin_sleep_wake_ctl dut_i (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .bit_tick(bit_tick),
      .bus_act(bus_act), .sync_det(sync_det), .sleep_cmd(sleep_cmd),
      .wake_req(wake_req), .idle_sel(idle_sel), .rep_sel(rep_sel),
      .wake_len(wake_len), .sleep_o(sleep_o), .wake_drive_o(wake_drive_o),
      .wake_stat_o(wake_stat_o), .idle_to_o(idle_to_o), .sync_to_o(sync_to_o)
   );

   // monitor: vector order {sleep, drive, wake_stat, idle_to, sync_to}
   always @(negedge clk) begin
      while (sb_q.size() > 0) begin
         logic [4:0] act;
         it  = sb_q.pop_front();
         act = {sleep_o, wake_drive_o, wake_stat_o, idle_to_o, sync_to_o};
         nchk++;
         if (act !== it.v) begin
            nerr++;
            $display("FAIL %s: actual=%b expected=%b", it.req, act, it.v);
         end
      end
   end

   task automatic cyc();
      @(posedge clk);
      #2;
   endtask

   task automatic expect_v(input string req, input logic [4:0] v);
      sb_q.push_back('{req, v});
   endtask

   task automatic ms(input int n);
      for (int i = 0; i < n; i++) begin
         ms_tick = 1'b1; cyc(); ms_tick = 1'b0; cyc();
      end
   endtask

   task automatic bits(input int n);
      for (int i = 0; i < n; i++) begin
         bit_tick = 1'b1; cyc(); bit_tick = 1'b0; cyc();
      end
   endtask

   task automatic strobe_act();   bus_act = 1'b1;   cyc(); bus_act = 1'b0;   endtask
   task automatic strobe_sync();  sync_det = 1'b1;  cyc(); sync_det = 1'b0;  endtask
   task automatic strobe_sleep(); sleep_cmd = 1'b1; cyc(); sleep_cmd = 1'b0; endtask
   task automatic strobe_wake();  wake_req = 1'b1;  cyc(); wake_req = 1'b0;  endtask

   initial begin
      repeat (3) cyc();
      rst_n = 1'b1;
      cyc();
      expect_v("R1 reset state", 5'b00000);
      cyc();

      // R2 idle code 00
      strobe_act();
      ms(3999); expect_v("R2 idle 00 one short", 5'b00000); cyc();
      ms(1);    expect_v("R2 idle 00 expiry", 5'b10010); cyc();
      strobe_act(); expect_v("R5 wake on bus activity", 5'b00100); cyc();

      // R3 restart on activity, idle code 01
      idle_sel = 2'b01;
      ms(5000); strobe_act();
      ms(5999); expect_v("R3 restart keeps awake", 5'b00100); cyc();
      ms(1);    expect_v("R3 idle 01 expiry after restart", 5'b10010); cyc();
      strobe_act(); expect_v("R5 wake again", 5'b00100); cyc();

      idle_sel = 2'b10;
      ms(7999); expect_v("R2 idle 10 one short", 5'b00100); cyc();
      ms(1);    expect_v("R2 idle 10 expiry", 5'b10010); cyc();
      strobe_act();

      idle_sel = 2'b11;
      ms(9999); expect_v("R2 idle 11 one short", 5'b00100); cyc();
      ms(1);    expect_v("R2 idle 11 expiry", 5'b10010); cyc();
      strobe_act();

      // R4 sleep command
      strobe_sleep(); expect_v("R4 sleep command", 5'b10000); cyc();

      // R6 pulse length, R7 sync in time
      wake_len = 3'd3;
      strobe_wake(); expect_v("R6 pulse starts", 5'b11100); cyc();
      bits(3); expect_v("R6 pulse held", 5'b11100); cyc();
      bits(1); expect_v("R6 pulse ends, sleep left", 5'b00100); cyc();
      ms(149); expect_v("R7 waiting, no timeout", 5'b00100); cyc();
      strobe_sync(); ms(200); expect_v("R7 sync kept node awake", 5'b00100); cyc();

      // R11 wake request while awake
      strobe_wake(); expect_v("R11 request while awake ignored", 5'b00100); cyc();

      // R8 timeout, R9 repeat, R10 stop after three
      strobe_sleep();
      rep_sel = 2'b01; wake_len = 3'd0;
      strobe_wake(); expect_v("R6 first attempt", 5'b11100); cyc();
      bits(1);
      ms(149); expect_v("R8 one short of timeout", 5'b00100); cyc();
      ms(1);   expect_v("R8 sync timeout", 5'b10101); cyc();
      ms(49);  expect_v("R9 one short of repeat 200", 5'b10101); cyc();
      ms(1);   expect_v("R9 second pulse at 200", 5'b11101); cyc();
      bits(1); ms(150); expect_v("R8 second timeout", 5'b10101); cyc();
      ms(50);  expect_v("R9 third pulse", 5'b11101); cyc();
      bits(1); ms(150); expect_v("R10 third timeout", 5'b10101); cyc();
      ms(300); expect_v("R10 no fourth pulse", 5'b10101); cyc();
      strobe_wake(); expect_v("R10 new request restarts", 5'b11100); cyc();
      bits(1); strobe_sync(); expect_v("R7 sync after restart", 5'b00100); cyc();

      // R9 repeat code 11
      strobe_sleep(); rep_sel = 2'b11;
      strobe_wake(); bits(1);
      ms(239); expect_v("R9 one short of repeat 240", 5'b10101); cyc();
      ms(1);   expect_v("R9 pulse at 240", 5'b11101); cyc();
      bits(1); strobe_sync(); expect_v("R10 awake clears timeout", 5'b00100); cyc();

      cyc();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         nerr++; nchk++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

endmodule